// File: doc/BRIEF.md
# Periodic Dataflow Actor Scheduler

This block drives the firing of a small dataflow system built from eight actors: six producers, one consumer that sorts the values it gathers and one consumer that passes them on unsorted. A program counter steps through a fixed cycle of time slots and wraps at the end. For each slot, combinational logic returns an eight-bit vector of actor enable strobes and a crossbar select word. The select word tells each consumer input port which producer's output to take. One schedule time unit is exactly one clock cycle.

An elaboration-time parameter picks one of three schedules:
- **Paired, period 2.** All producers fire together, and both consumers fire in the next slot.
- **Streaming, period 1.** Every actor fires on every cycle. This suits a buffer depth of two on every producer-to-consumer link.
- **Serial, period `NUM_PROD+1`.** The producers fire one at a time. Both consumers fire in the last slot.

The datapath actors and their buffers sit outside this block. They take `actor_en` and `xbar_sel` directly.

Top module: `periodic_actor_sched`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises (before the first clock edge), `actor_en` is all zeros. In the same window `xbar_sel` holds the default routing: the 3-bit field k (bits 3k+2..3k) of `xbar_sel` carries source index k mod `NUM_PROD`, for k from 0 to 2·`NUM_PROD`−1.
- R2: The first clock edge after `rst_n` rises starts slot 0. The outputs show slot 0 for the cycle that follows.
- R3: The bit mapping of `actor_en` is as follows. Bits 0 to `NUM_PROD`−1 enable producers 0 to `NUM_PROD`−1. Bit `NUM_PROD` enables the sorting consumer. Bit `NUM_PROD`+1 enables the pass-through consumer.
- R4: With `VARIANT`=0 the period is 2. Slot 0 enables every producer and neither consumer. Slot 1 enables both consumers and no producer.
- R5: With `VARIANT`=1 the period is 1. All `NUM_PROD`+2 enables are high on every cycle after start.
- R6: With `VARIANT`=2 the period is `NUM_PROD`+1. Slot s < `NUM_PROD` enables only producer s. In that slot, ports 0 and `NUM_PROD` of the crossbar carry source index s. The last slot enables both consumers and no producer.
- R7: The slot advances by one on every clock edge and wraps from period−1 back to 0, so each enable pattern repeats exactly once per period.
- R8: Apart from the producer slots of R6, `xbar_sel` holds the default routing of R1 in every slot.
- R9: With `VARIANT` 0 or 2, no cycle enables a producer and a consumer together. With `VARIANT` 2, at most one producer is enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one schedule time unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| actor_en | output | NUM_PROD+2 | Per-actor fire strobes for the current slot |
| xbar_sel | output | 2·NUM_PROD·SEL_W | Crossbar source index per consumer port, SEL_W bits each |

## Verification
The bench runs all three schedule variants side by side and compares each against a behavioural slot model on every cycle. The run covers more than two full periods of the longest schedule and includes a reset applied in the middle of a period.

The corner cases it targets are these:
- **Reset and start-up.** A design that leaks slot 0 during reset would fail, and so would one that starts at slot 1 after reset.
- **Wrap point.** An off-by-one wrap would stretch or shorten the serial period, which shows up as a producer firing twice or the consumers firing a cycle early.
- **Serial crossbar.** A routing error would leave ports 0 and `NUM_PROD` on a stale producer, or would disturb the ports that should keep their default.

// File: rtl/actor_sched_pkg.sv
package actor_sched_pkg;

    // Schedule variants selectable at elaboration time.
    localparam int unsigned SCHED_PAIRED    = 0;
    localparam int unsigned SCHED_STREAMING = 1;
    localparam int unsigned SCHED_SERIAL    = 2;

    // Number of slots in one period for a given variant.
    function automatic int unsigned sched_period(input int unsigned variant,
                                                 input int unsigned num_prod);
        case (variant)
            SCHED_PAIRED:    return 2;
            SCHED_STREAMING: return 1;
            default:         return num_prod + 1;
        endcase
    endfunction

    // Width of an index, at least one bit.
    function automatic int unsigned idx_width(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/actor_sched_pc.sv
module actor_sched_pc
    import actor_sched_pkg::*;
#(
    parameter int unsigned PERIOD = 2,
    localparam int unsigned PC_W  = idx_width(PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            running,
    output logic [PC_W-1:0] slot
);

    localparam logic [PC_W-1:0] LAST_SLOT = PC_W'(PERIOD - 1);

    typedef struct packed {
        logic            running;
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    generate
        if (PERIOD == 1) begin : g_single
            // One slot only: the counter is constant, and the start flag is the only state.
            always_comb begin
                st_d         = st_q;
                st_d.running = 1'b1;
                st_d.pc      = '0;
            end
        end else begin : g_wrap
            always_comb begin
                st_d = st_q;
                if (!st_q.running) begin
                    st_d.running = 1'b1;
                    st_d.pc      = '0;
                end else if (st_q.pc == LAST_SLOT) begin
                    st_d.pc = '0;
                end else begin
                    st_d.pc = st_q.pc + PC_W'(1);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.running;
    assign slot    = st_q.pc;

    AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pc <= LAST_SLOT); // R7

    AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.running) |-> st_q.pc == '0); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.running && st_q.pc == LAST_SLOT) |=> st_q.pc == '0); // R7

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.running && st_q.pc != LAST_SLOT) |=> st_q.pc == $past(st_q.pc) + PC_W'(1)); // R7

endmodule

// File: rtl/actor_sched_rom.sv
module actor_sched_rom
    import actor_sched_pkg::*;
#(
    parameter int unsigned VARIANT  = SCHED_PAIRED,
    parameter int unsigned NUM_PROD = 6,
    localparam int unsigned PERIOD  = sched_period(VARIANT, NUM_PROD),
    localparam int unsigned PC_W    = idx_width(PERIOD),
    localparam int unsigned EN_W    = NUM_PROD + 2,
    localparam int unsigned SEL_W   = idx_width(NUM_PROD),
    localparam int unsigned NUM_XP  = 2 * NUM_PROD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    running,
    input  logic [PC_W-1:0]         slot,
    output logic [EN_W-1:0]         actor_en,
    output logic [NUM_XP*SEL_W-1:0] xbar_sel
);

    localparam int unsigned SORT_BIT = NUM_PROD;
    localparam int unsigned PASS_BIT = NUM_PROD + 1;

    logic [NUM_XP*SEL_W-1:0] default_sel;
    logic [EN_W-1:0]         en_raw;
    logic [NUM_XP*SEL_W-1:0] sel_raw;

    // Default routing: port k reads producer k mod NUM_PROD.
    generate
        for (genvar k = 0; k < NUM_XP; k++) begin : g_defsel
            assign default_sel[k*SEL_W +: SEL_W] = SEL_W'(k % NUM_PROD);
        end
    endgenerate

    generate
        if (VARIANT == SCHED_PAIRED) begin : g_paired
            always_comb begin
                en_raw  = '0;
                sel_raw = default_sel;
                if (slot == '0) begin
                    en_raw[NUM_PROD-1:0] = '1;
                end else begin
                    en_raw[SORT_BIT] = 1'b1;
                    en_raw[PASS_BIT] = 1'b1;
                end
            end
        end else if (VARIANT == SCHED_STREAMING) begin : g_stream
            always_comb begin
                en_raw  = '1;
                sel_raw = default_sel;
            end
        end else begin : g_serial
            always_comb begin
                en_raw  = '0;
                sel_raw = default_sel;
                if (32'(slot) < NUM_PROD) begin
                    en_raw[slot]                        = 1'b1;
                    sel_raw[0 +: SEL_W]                 = SEL_W'(slot);
                    sel_raw[NUM_PROD*SEL_W +: SEL_W]    = SEL_W'(slot);
                end else begin
                    en_raw[SORT_BIT] = 1'b1;
                    en_raw[PASS_BIT] = 1'b1;
                end
            end
        end
    endgenerate

    assign actor_en = running ? en_raw : '0;
    assign xbar_sel = running ? sel_raw : default_sel;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> actor_en == '0); // R1

    generate
        if (VARIANT != SCHED_STREAMING) begin : g_excl
            AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
                !((|actor_en[NUM_PROD-1:0]) && (|actor_en[PASS_BIT:SORT_BIT]))); // R9
        end
        if (VARIANT == SCHED_SERIAL) begin : g_one
            AST_ONE_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(actor_en[NUM_PROD-1:0]) <= 1); // R9
            AST_CONSUMERS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
                actor_en[SORT_BIT] == actor_en[PASS_BIT]); // R6
        end
    endgenerate

endmodule

// File: rtl/periodic_actor_sched.sv
module periodic_actor_sched
    import actor_sched_pkg::*;
#(
    parameter int unsigned VARIANT  = SCHED_PAIRED,
    parameter int unsigned NUM_PROD = 6,
    localparam int unsigned PERIOD  = sched_period(VARIANT, NUM_PROD),
    localparam int unsigned PC_W    = idx_width(PERIOD),
    localparam int unsigned EN_W    = NUM_PROD + 2,
    localparam int unsigned SEL_W   = idx_width(NUM_PROD),
    localparam int unsigned NUM_XP  = 2 * NUM_PROD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [EN_W-1:0]         actor_en,
    output logic [NUM_XP*SEL_W-1:0] xbar_sel
);

    logic            running;
    logic [PC_W-1:0] slot;

    actor_sched_pc #(
        .PERIOD (PERIOD)
    ) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .slot    (slot)
    );

    actor_sched_rom #(
        .VARIANT  (VARIANT),
        .NUM_PROD (NUM_PROD)
    ) u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .slot     (slot),
        .actor_en (actor_en),
        .xbar_sel (xbar_sel)
    );

    // Every actor fires exactly once per period: a producer firing in slot 0 of a multi-slot schedule does not fire again on the next cycle.
    generate
        if (PERIOD > 1) begin : g_period
            AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
                actor_en[0] |=> !actor_en[0]); // R7
        end
    endgenerate

endmodule

// File: tb/sim_periodic_actor_sched.sv
`timescale 1ns/1ps
module sim_periodic_actor_sched;

    localparam int NP    = 6;
    localparam int EN_W  = NP + 2;
    localparam int SEL_W = 3;
    localparam int NXP   = 2 * NP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    logic [EN_W-1:0]      en   [3];
    logic [NXP*SEL_W-1:0] sel  [3];

    periodic_actor_sched #(.VARIANT(0), .NUM_PROD(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .actor_en(en[0]), .xbar_sel(sel[0]));
    periodic_actor_sched #(.VARIANT(1), .NUM_PROD(NP)) u1 (
        .clk(clk), .rst_n(rst_n), .actor_en(en[1]), .xbar_sel(sel[1]));
    periodic_actor_sched #(.VARIANT(2), .NUM_PROD(NP)) u2 (
        .clk(clk), .rst_n(rst_n), .actor_en(en[2]), .xbar_sel(sel[2]));

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Behavioural slot model: started flag and cycles since start.
    bit started [3];
    int n       [3];

    function automatic int period_of(input int v);
        return (v == 0) ? 2 : (v == 1) ? 1 : NP + 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        for (int v = 0; v < 3; v++) begin
            if (!rst_n) begin
                started[v] = 1'b0;
                n[v]       = 0;
            end else if (!started[v]) begin
                started[v] = 1'b1;
                n[v]       = 0;
            end else begin
                n[v] = n[v] + 1;
            end
        end
    end

    // R3: bits 0..NP-1 producers, bit NP sorter, bit NP+1 pass-through.
    function automatic logic [EN_W-1:0] ref_en(input int v, input int s);
        logic [EN_W-1:0] r;
        r = '0;
        if (v == 1) r = '1;                                        // R5
        else if (v == 0) begin                                     // R4
            if (s == 0) r[NP-1:0] = '1; else r[NP+1:NP] = 2'b11;
        end else begin                                             // R6
            if (s < NP) r[s] = 1'b1; else r[NP+1:NP] = 2'b11;
        end
        return r;
    endfunction

    // R1/R8 default routing; R6 serial producer routing on ports 0 and NP.
    function automatic logic [NXP*SEL_W-1:0] ref_sel(input int v, input bit act, input int s);
        logic [NXP*SEL_W-1:0] r;
        for (int p = 0; p < NXP; p++) begin
            int src = p % NP;
            if (act && v == 2 && s < NP && (p == 0 || p == NP)) src = s;
            r[p*SEL_W +: SEL_W] = SEL_W'(src);
        end
        return r;
    endfunction

    task automatic check_all();
        for (int v = 0; v < 3; v++) begin
            int s = n[v] % period_of(v);
            bit act = rst_n && started[v];
            logic [EN_W-1:0]      xe = act ? ref_en(v, s) : '0;
            logic [NXP*SEL_W-1:0] xs = ref_sel(v, act, s);
            string tag;
            if (!act)                 tag = "R1";
            else if (n[v] == 0)       tag = "R2";
            else if (s == 0)          tag = "R7";
            else if (v == 0)          tag = "R4";
            else if (v == 1)          tag = "R5";
            else                      tag = "R6";
            checks++;
            if (en[v] !== xe) begin
                fails++;
                $display("FAIL %s variant %0d enables: actual %b expected %b", tag, v, en[v], xe);
            end
            checks++;
            if (sel[v] !== xs) begin
                fails++;
                $display("FAIL %s/R8 variant %0d xbar: actual %h expected %h", tag, v, sel[v], xs);
            end
            if (v != 1) begin
                checks++;
                if ((|en[v][NP-1:0]) && (|en[v][NP+1:NP])) begin
                    fails++;
                    $display("FAIL R9 variant %0d overlap: actual %b expected no overlap", v, en[v]);
                end
            end
        end
    endtask

    always @(negedge clk) check_all();

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (23) @(posedge clk);       // over two serial periods, then mid-period reset
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        #1 finish_run();
    end

endmodule